// File: doc/BRIEF.md
# Relocation Window Guard and Fault Recorder

This block sits between a processor's address generation and its memory. Every reference arrives as a relative address with a kind tag. The block adds a relocation base to form the absolute address. It compares the relative address against the program's window length and forwards only in-range references to memory. It also records fault events from the start of the current program: an address outside the window, an infinite operand from the floating unit, and an indefinite operand from the floating unit.

A three-bit exit selector chooses which faults halt the program. Every fault is remembered, whether it is selected or not. When a selected fault occurs, the block raises a one-cycle stop pulse and holds a halted status. It also emits one write of a stop word at the relocation base. That word carries the combined fault code and the program address. While halted, the block refuses new references. A context-switch clear wipes the recorded faults and releases the halt.

The reference input is a valid/ready stream. `ref_ready` is high whenever the block is not halted. A reference counts only on a cycle where both `ref_valid` and `ref_ready` are high. The memory side has no back-pressure: `abs_valid` is a one-cycle qualifier. The fault flags, the selector and the clear are plain control pins.

Top module: `reloc_guard`

## Requirements
- R1: `abs_addr` equals `ref_addr + base_addr` modulo 2^18, combinationally.
- R2: A reference is in range exactly when `ref_addr < field_len`. The highest in-range address is `field_len - 1`. `range_err` is high when `ref_addr >= field_len`. With `field_len` = 0, every address is out of range.
- R3: `abs_valid` is high only for an accepted reference that is in range. It also requires `ref_valid`, `ref_ready`, and `range_err` low.
- R4: Fault codes are: bit 0 for an accepted out-of-range reference, bit 1 for `inf_flag`, and bit 2 for `indef_flag`. A fault stops the block only when its bit is set in `exit_sel`. With `exit_sel` = 0, the block never stops.
- R5: Faults accumulate in a sticky code, whether or not they are selected. The code is cleared only by `xj_clear` (or reset).
- R6: A stop follows a cycle in which the running block sees a selected fault. On the next clock edge, `stop_pulse` goes high for exactly one cycle, `halted` rises, and `wb_valid` pulses for one cycle. `wb_addr` equals `base_addr`.
- R7: The stop word has bits 59:57 = 0, which is the stop-group opcode. Bits 56:54 hold the sticky code OR the faults of the stopping cycle. Bits 47:30 hold `prog_addr`, and all other bits are 0. Simultaneous faults combine, for example code 3.
- R8: While `halted`, `ref_ready` is low. Fault flags and references are ignored: no further stop pulse or write occurs.
- R9: `xj_clear` takes priority over faults in the same cycle. It releases `halted` on the next edge and empties the sticky code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_valid | input | 1 | Reference offered |
| ref_ready | output | 1 | Reference accepted (not halted) |
| ref_addr | input | 18 | Relative address |
| ref_kind | input | 2 | Reference kind: 0 fetch, 1 branch, 2 read, 3 write |
| base_addr | input | 18 | Relocation base |
| field_len | input | 18 | Window length |
| exit_sel | input | 3 | Fault selector |
| inf_flag | input | 1 | Infinite operand event |
| indef_flag | input | 1 | Indefinite operand event |
| prog_addr | input | 18 | Current program address |
| xj_clear | input | 1 | Context-switch clear |
| abs_addr | output | 18 | Absolute address |
| abs_kind | output | 2 | Kind forwarded with the address |
| abs_valid | output | 1 | In-range reference to memory |
| range_err | output | 1 | Address outside window |
| stop_pulse | output | 1 | One-cycle stop request |
| halted | output | 1 | Stopped status |
| wb_valid | output | 1 | Stop-word write strobe |
| wb_addr | output | 18 | Stop-word address |
| wb_word | output | 60 | Stop word |

## Verification
The checker watches several rules on every cycle:
- the stop pulse lasts one cycle and coincides with a halt;
- a halt blocks the stream and persists until a clear;
- a clear releases the halt;
- forwarded references are inside the window;
- the stop word carries a zero top digit and the relocation base as its address.

Other behaviour can only be shown by the bench's scenarios:
- an unselected fault that is hidden until a later selected one;
- combined codes from faults in the same cycle;
- an emptied code after a clear;
- the exact address sums at the window edge.

// File: rtl/reloc_guard_pkg.sv
package reloc_guard_pkg;
  localparam int ADDR_W   = 18;
  localparam int WORD_W   = 60;
  localparam int CODE_W   = 3;
  localparam int CODE_LSB = 54;
  localparam int PA_LSB   = 30;
  localparam int OP_LSB   = 57;

  typedef enum logic [1:0] {
    KIND_FETCH  = 2'd0,
    KIND_BRANCH = 2'd1,
    KIND_READ   = 2'd2,
    KIND_WRITE  = 2'd3
  } ref_kind_e;

  localparam int BIT_ADDR  = 0;
  localparam int BIT_INF   = 1;
  localparam int BIT_INDEF = 2;
endpackage

// File: rtl/reloc_window.sv
module reloc_window #(
  parameter int AW = 18
) (
  input  logic [AW-1:0] rel_addr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] len,
  output logic [AW-1:0] abs_out,
  output logic          outside
);
  always_comb begin
    abs_out = rel_addr + base;
    outside = (rel_addr >= len);
  end
endmodule

// File: rtl/fault_accum.sv
module fault_accum #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          running,
  input  logic [CW-1:0] events,
  input  logic [CW-1:0] select,
  output logic          hit,
  output logic [CW-1:0] code_now
);
  logic [CW-1:0] sticky_q;
  logic [CW-1:0] live;

  always_comb begin
    live     = running ? events : '0;
    code_now = sticky_q | live;
    hit      = running && !clear && ((live & select) != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) sticky_q <= '0;
    else                 sticky_q <= code_now;
  end
endmodule

// File: rtl/stop_ctl.sv
module stop_ctl
  import reloc_guard_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int WW = WORD_W,
  parameter int CW = CODE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          hit,
  input  logic [CW-1:0] code,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] pc,
  output logic          halted,
  output logic          stop_pulse,
  output logic          wb_valid,
  output logic [AW-1:0] wb_addr,
  output logic [WW-1:0] wb_word
);
  logic [WW-1:0] word_d;

  always_comb begin
    word_d = '0;
    word_d[CODE_LSB +: CW] = code;
    word_d[PA_LSB +: AW]   = pc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halted     <= 1'b0;
      stop_pulse <= 1'b0;
      wb_valid   <= 1'b0;
      wb_addr    <= '0;
      wb_word    <= '0;
    end else begin
      stop_pulse <= hit;
      wb_valid   <= hit;
      if (clear)    halted <= 1'b0;
      else if (hit) halted <= 1'b1;
      if (hit) begin
        wb_addr <= base;
        wb_word <= word_d;
      end
    end
  end
endmodule

// File: rtl/reloc_guard.sv
module reloc_guard
  import reloc_guard_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ref_valid,
  output logic                ref_ready,
  input  logic [ADDR_W-1:0]   ref_addr,
  input  logic [1:0]          ref_kind,
  input  logic [ADDR_W-1:0]   base_addr,
  input  logic [ADDR_W-1:0]   field_len,
  input  logic [CODE_W-1:0]   exit_sel,
  input  logic                inf_flag,
  input  logic                indef_flag,
  input  logic [ADDR_W-1:0]   prog_addr,
  input  logic                xj_clear,
  output logic [ADDR_W-1:0]   abs_addr,
  output logic [1:0]          abs_kind,
  output logic                abs_valid,
  output logic                range_err,
  output logic                stop_pulse,
  output logic                halted,
  output logic                wb_valid,
  output logic [ADDR_W-1:0]   wb_addr,
  output logic [WORD_W-1:0]   wb_word
);
  logic              accepted;
  logic [CODE_W-1:0] events;
  logic [CODE_W-1:0] code_now;
  logic              hit;

  reloc_window #(.AW(ADDR_W)) u_win (
    .rel_addr(ref_addr), .base(base_addr), .len(field_len),
    .abs_out(abs_addr), .outside(range_err)
  );

  always_comb begin
    ref_ready = !halted;
    accepted  = ref_valid && ref_ready;
    abs_valid = accepted && !range_err;
    abs_kind  = ref_kind;
    events            = '0;
    events[BIT_ADDR]  = accepted && range_err;
    events[BIT_INF]   = inf_flag;
    events[BIT_INDEF] = indef_flag;
  end

  fault_accum #(.CW(CODE_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clear(xj_clear), .running(!halted),
    .events(events), .select(exit_sel), .hit(hit), .code_now(code_now)
  );

  stop_ctl #(.AW(ADDR_W), .WW(WORD_W), .CW(CODE_W)) u_stop (
    .clk(clk), .rst_n(rst_n), .clear(xj_clear), .hit(hit), .code(code_now),
    .base(base_addr), .pc(prog_addr), .halted(halted), .stop_pulse(stop_pulse),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_word(wb_word)
  );
endmodule

// File: rtl/reloc_guard_checker.sv
module reloc_guard_checker
  import reloc_guard_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ref_ready,
  input logic [ADDR_W-1:0] ref_addr,
  input logic [ADDR_W-1:0] base_addr,
  input logic [ADDR_W-1:0] field_len,
  input logic              xj_clear,
  input logic              abs_valid,
  input logic              stop_pulse,
  input logic              halted,
  input logic              wb_valid,
  input logic [ADDR_W-1:0] wb_addr,
  input logic [WORD_W-1:0] wb_word
);
  assert_fwd_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    abs_valid |-> (ref_addr < field_len));

  assert_stop_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |=> !stop_pulse);

  assert_stop_halts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |-> (halted && wb_valid));

  assert_wb_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wb_valid) |-> (wb_addr == $past(base_addr)));

  assert_word_opcode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_word[WORD_W-1:OP_LSB] == '0));

  assert_halt_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !ref_ready);

  assert_halt_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !xj_clear) |=> (halted && !stop_pulse));

  assert_clear_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xj_clear |=> !halted);
endmodule

bind reloc_guard reloc_guard_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ref_ready(ref_ready), .ref_addr(ref_addr),
  .base_addr(base_addr), .field_len(field_len), .xj_clear(xj_clear),
  .abs_valid(abs_valid), .stop_pulse(stop_pulse), .halted(halted),
  .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_word(wb_word)
);

// File: tb/reloc_guard_tb_top.sv
`timescale 1ns/100ps
module reloc_guard_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, ref_valid, ref_ready, inf_flag, indef_flag, xj_clear;
  logic [17:0] ref_addr, base_addr, field_len, prog_addr, abs_addr, wb_addr;
  logic [1:0] ref_kind, abs_kind;
  logic [2:0] exit_sel;
  logic abs_valid, range_err, stop_pulse, halted, wb_valid;
  logic [59:0] wb_word;

  reloc_guard dut_i (.*);

  int n_checks = 0;
  int n_fail = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [59:0] stop_word(input logic [2:0] c, input logic [17:0] p);
    return (60'(c) << 54) | (60'(p) << 30);
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  localparam int NV = 6;
  localparam logic [17:0] V_ADDR [NV] = '{18'd0, 18'd99, 18'd100, 18'd5, 18'd0, 18'd2};
  localparam logic [17:0] V_BASE [NV] = '{18'd0, 18'd0, 18'd0, 18'd512, 18'd1000, 18'h3FFFF};
  localparam logic [17:0] V_LEN  [NV] = '{18'd100, 18'd100, 18'd100, 18'd10, 18'd0, 18'd10};
  localparam logic [17:0] V_ABS  [NV] = '{18'd0, 18'd99, 18'd100, 18'd517, 18'd1000, 18'd1};
  localparam logic        V_ERR  [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};

  initial begin
    #150000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; ref_valid = 0; ref_addr = 0; ref_kind = 0; base_addr = 0;
    field_len = 18'd100; exit_sel = 0; inf_flag = 0; indef_flag = 0;
    prog_addr = 18'o1234; xj_clear = 0;
    tick(); tick();
    rst_n = 1; tick();
    // reset state, R6 R8
    chk("R6 reset halted", 64'(halted), 0);
    chk("R6 reset stop", 64'(stop_pulse), 0);
    chk("R6 reset wb", 64'(wb_valid), 0);
    chk("R8 reset ready", 64'(ref_ready), 1);

    // vector table, exit_sel = 0 so nothing stops (R1 R2 R3 R4)
    ref_valid = 1; ref_kind = 2'd3;
    for (int i = 0; i < NV; i++) begin
      ref_addr = V_ADDR[i]; base_addr = V_BASE[i]; field_len = V_LEN[i];
      #1;
      chk("R1 abs", 64'(abs_addr), 64'(V_ABS[i]));
      chk("R2 range", 64'(range_err), 64'(V_ERR[i]));
      chk("R3 fwd", 64'(abs_valid), 64'(!V_ERR[i]));
      chk("R3 kind", 64'(abs_kind), 64'd3);
      tick();
    end
    chk("R4 no stop when unselected", 64'(halted), 0);

    // clean start, window edge at base+len-1 (R2)
    ref_valid = 0; xj_clear = 1; tick(); xj_clear = 0;
    base_addr = 18'd4000; field_len = 18'd64; ref_valid = 1; ref_addr = 18'd63; #1;
    chk("R2 last in-range", 64'(range_err), 0);
    chk("R1 edge abs", 64'(abs_addr), 64'd4063);

    // unselected address fault remembered, later selected inf stops (R5 R6 R7)
    exit_sel = 3'b010; ref_addr = 18'd64; tick();
    ref_valid = 0;
    chk("R5 unselected no stop", 64'(halted), 0);
    tick();
    prog_addr = 18'o7070; inf_flag = 1; #1;
    tick(); inf_flag = 0;
    chk("R6 stop pulse", 64'(stop_pulse), 1);
    chk("R6 halted", 64'(halted), 1);
    chk("R6 wb strobe", 64'(wb_valid), 1);
    chk("R6 wb addr", 64'(wb_addr), 64'd4000);
    chk("R7 combined code 3", 64'(wb_word), 64'(stop_word(3'd3, 18'o7070)));
    // halted ignores faults (R8)
    ref_valid = 1; indef_flag = 1; exit_sel = 3'b111; #1;
    chk("R8 not ready", 64'(ref_ready), 0);
    chk("R8 no fwd", 64'(abs_valid), 0);
    tick(); indef_flag = 0; ref_valid = 0;
    chk("R6 pulse single", 64'(stop_pulse), 0);
    chk("R8 no second write", 64'(wb_valid), 0);
    tick();
    chk("R8 still halted", 64'(halted), 1);

    // clear beats a fault in the same cycle (R9)
    xj_clear = 1; inf_flag = 1; tick(); xj_clear = 0; inf_flag = 0;
    chk("R9 released", 64'(halted), 0);
    chk("R9 no stop at clear", 64'(stop_pulse), 0);
    // code emptied: indef alone gives 4 (R9 R7)
    exit_sel = 3'b100; prog_addr = 18'd5; indef_flag = 1; tick(); indef_flag = 0;
    chk("R9 fresh code 4", 64'(wb_word), 64'(stop_word(3'd4, 18'd5)));

    // simultaneous selected faults combine (R7)
    xj_clear = 1; tick(); xj_clear = 0;
    exit_sel = 3'b111; ref_valid = 1; ref_addr = 18'd200; inf_flag = 1; prog_addr = 18'd9;
    tick(); ref_valid = 0; inf_flag = 0;
    chk("R7 same-cycle code 3", 64'(wb_word), 64'(stop_word(3'd3, 18'd9)));
    chk("R7 stop", 64'(stop_pulse), 1);

    // exit_sel 0 with every fault (R4)
    xj_clear = 1; tick(); xj_clear = 0;
    exit_sel = 0; ref_valid = 1; inf_flag = 1; indef_flag = 1; tick();
    ref_valid = 0; inf_flag = 0; indef_flag = 0; tick();
    chk("R4 sel zero never stops", 64'(halted), 0);
    // then select inf alone: code shows all three remembered (R5)
    exit_sel = 3'b010; inf_flag = 1; tick(); inf_flag = 0;
    chk("R5 sticky 7", 64'(wb_word[56:54]), 64'd7);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule